// File: doc/BRIEF.md
# Frame Engine Run Controller

This block decides when a frame-based image processing engine runs. Software writes a control word that holds an enable bit, a single-frame bit and an input-select bit. Start-of-frame and end-of-frame strobes come from two places: a memory fetch path and a live sensor front end. The block turns the control word and these strobes into a processing-enable level, a BUSY status bit and a one-cycle pulse that tells the memory fetch path to begin.

Memory input always runs for a single frame. Writing the enable bit with memory selected arms the engine at once and sends the fetch pulse. Sensor input follows the sensor's own frame timing. In continuous mode a frame is started at every sensor start-of-frame for as long as enable is set. In single-frame mode the control fields clear themselves when the frame begins.

The block also holds a bank of configuration registers in two copies. Writes go to a staging copy, and software reads back the staging copy at once. The staging copy is moved into the active copy, which the datapath uses, in the cycle a frame starts.

Top module: `frame_run_ctrl`

## Requirements
- R1: After reset the control word reads back as zero, BUSY, proc_en and fetch_start are low, and every staged and active configuration entry is zero.
- R2: In the control word, bit 0 is enable, bit 3 is single-frame and bit 4 selects the input (1 = memory, 0 = sensor). A write with bits 0 and 4 both set gives a one-cycle fetch_start in the next cycle, and the control word then reads back as zero whatever bit 3 was.
- R3: After such a memory write, the next mem_sof starts exactly one frame (BUSY rises the cycle after it). Later mem_sof strobes start nothing until memory is armed again.
- R4: With sensor input selected and enable set, the engine starts no frame until a sen_sof arrives. BUSY and proc_en rise in the cycle after that strobe.
- R5: With sensor input, enable and single-frame set, the control word reads back as zero from the cycle after the frame starts, and no further frame starts.
- R6: In continuous sensor mode, clearing enable during a frame does not end it. BUSY stays high until the sen_eof and then falls, and no further sensor frame starts.
- R7: A start-of-frame while BUSY is high is ignored. An end-of-frame from the input that is not running the current frame does not clear BUSY. proc_en always equals BUSY.
- R8: A configuration write can be read back on shd_rdata in the next cycle. The active copy changes only in the cycle after a frame starts, and then it takes the staged values.
- R9: If a configuration write and a frame start fall in the same cycle, the active copy takes the value that was staged before that write. The new value stays staged until the following frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | CTL_W | Control word write data |
| ctl_rdata | output | CTL_W | Control word read back |
| shd_wr | input | 1 | Configuration entry write strobe |
| shd_addr | input | $clog2(NUM_SHD) | Configuration entry index for write and read |
| shd_wdata | input | SHD_W | Configuration write data |
| shd_rdata | output | SHD_W | Staged value of the addressed entry |
| shd_active | output | NUM_SHD*SHD_W | Active copy of all entries, entry i at bits i*SHD_W upward |
| sen_sof | input | 1 | Sensor start-of-frame strobe |
| sen_eof | input | 1 | Sensor end-of-frame strobe |
| mem_sof | input | 1 | Memory path start-of-frame strobe |
| mem_eof | input | 1 | Memory path end-of-frame strobe |
| fetch_start | output | 1 | One-cycle request for the memory path to start fetching |
| proc_en | output | 1 | Processing enable for the datapath |
| busy | output | 1 | Frame-in-progress status |

## Verification
The bench targets the cycle where a register write and a frame strobe meet. A design that commits the new write instead of the staged one breaks R9. A design that lets a sensor single-frame clear override a write in the same cycle loses software's new setting. A design that stops continuous mode as soon as enable clears cuts the current frame short instead of waiting for its end. A design that accepts an end strobe from the idle input ends frames early. One that accepts a second start during a frame re-commits the configuration partway through the frame. A design that honours the single-frame bit only for sensor input would leave memory mode enabled, and the readback check catches that.

// File: rtl/frc_pkg.sv
package frc_pkg;
   localparam int BIT_EN  = 0;
   localparam int BIT_ONE = 3;
   localparam int BIT_SRC = 4;
   typedef enum logic {SRC_SENSOR = 1'b0, SRC_MEM = 1'b1} src_e;
endpackage

// File: rtl/frc_ctl_regs.sv
module frc_ctl_regs #(
   parameter int CTL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CTL_W-1:0] wdata,
   input  logic             frame_start,
   input  logic             start_is_mem,
   output logic             en,
   output logic             one,
   output logic             src,
   output logic             mem_pend,
   output logic             fetch_start,
   output logic [CTL_W-1:0] rdata
);
   import frc_pkg::*;

   logic mem_arm_wr;
   assign mem_arm_wr = wdata[BIT_EN] & wdata[BIT_SRC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en          <= 1'b0;
         one         <= 1'b0;
         src         <= 1'b0;
         mem_pend    <= 1'b0;
         fetch_start <= 1'b0;
      end else begin
         fetch_start <= 1'b0;
         if (frame_start && start_is_mem)
            mem_pend <= 1'b0;
         if (frame_start && !start_is_mem && one) begin
            en  <= 1'b0;
            one <= 1'b0;
            src <= 1'b0;
         end
         if (wr) begin
            if (mem_arm_wr) begin
               en          <= 1'b0;
               one         <= 1'b0;
               src         <= 1'b0;
               mem_pend    <= 1'b1;
               fetch_start <= 1'b1;
            end else begin
               en  <= wdata[BIT_EN];
               one <= wdata[BIT_ONE];
               src <= wdata[BIT_SRC];
            end
         end
      end
   end

   always_comb begin
      rdata          = '0;
      rdata[BIT_EN]  = en;
      rdata[BIT_ONE] = one;
      rdata[BIT_SRC] = src;
   end
endmodule

// File: rtl/frc_frame_seq.sv
module frc_frame_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic src,
   input  logic mem_pend,
   input  logic sen_sof,
   input  logic sen_eof,
   input  logic mem_sof,
   input  logic mem_eof,
   output logic frame_start,
   output logic start_is_mem,
   output logic busy
);
   import frc_pkg::*;

   src_e cur_src;
   logic sen_go;
   logic cur_eof;

   assign start_is_mem = mem_pend & mem_sof;
   assign sen_go       = en & (src == SRC_SENSOR) & sen_sof;
   assign frame_start  = ~busy & (start_is_mem | sen_go);
   assign cur_eof      = (cur_src == SRC_MEM) ? mem_eof : sen_eof;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         cur_src <= SRC_SENSOR;
      end else if (frame_start) begin
         busy    <= 1'b1;
         cur_src <= start_is_mem ? SRC_MEM : SRC_SENSOR;
      end else if (busy && cur_eof) begin
         busy <= 1'b0;
      end
   end
endmodule

// File: rtl/frc_shadow_bank.sv
module frc_shadow_bank #(
   parameter int NUM_SHD = 4,
   parameter int SHD_W   = 16,
   localparam int AW     = $clog2(NUM_SHD)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr,
   input  logic [AW-1:0]            addr,
   input  logic [SHD_W-1:0]         wdata,
   input  logic                     commit,
   output logic [SHD_W-1:0]         rdata,
   output logic [NUM_SHD*SHD_W-1:0] active
);
   logic [SHD_W-1:0] staged [NUM_SHD];

   for (genvar i = 0; i < NUM_SHD; i++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            staged[i]               <= '0;
            active[i*SHD_W +: SHD_W] <= '0;
         end else begin
            if (commit)
               active[i*SHD_W +: SHD_W] <= staged[i];
            if (wr && (addr == AW'(i)))
               staged[i] <= wdata;
         end
      end
   end

   assign rdata = staged[addr];
endmodule

// File: rtl/frame_run_ctrl.sv
module frame_run_ctrl #(
   parameter int CTL_W   = 8,
   parameter int NUM_SHD = 4,
   parameter int SHD_W   = 16,
   localparam int AW     = $clog2(NUM_SHD)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ctl_wr,
   input  logic [CTL_W-1:0]         ctl_wdata,
   output logic [CTL_W-1:0]         ctl_rdata,
   input  logic                     shd_wr,
   input  logic [AW-1:0]            shd_addr,
   input  logic [SHD_W-1:0]         shd_wdata,
   output logic [SHD_W-1:0]         shd_rdata,
   output logic [NUM_SHD*SHD_W-1:0] shd_active,
   input  logic                     sen_sof,
   input  logic                     sen_eof,
   input  logic                     mem_sof,
   input  logic                     mem_eof,
   output logic                     fetch_start,
   output logic                     proc_en,
   output logic                     busy
);
   if (CTL_W < 5) begin : g_bad_ctl
      $error("CTL_W must hold the control fields up to bit 4");
   end
   if (NUM_SHD < 2) begin : g_bad_num
      $error("NUM_SHD must be at least 2");
   end
   if (SHD_W < 1) begin : g_bad_w
      $error("SHD_W must be positive");
   end

   logic en, one, src, mem_pend;
   logic frame_start, start_is_mem;

   frc_ctl_regs #(.CTL_W(CTL_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
      .frame_start(frame_start), .start_is_mem(start_is_mem),
      .en(en), .one(one), .src(src), .mem_pend(mem_pend),
      .fetch_start(fetch_start), .rdata(ctl_rdata)
   );

   frc_frame_seq u_seq (
      .clk(clk), .rst_n(rst_n), .en(en), .src(src), .mem_pend(mem_pend),
      .sen_sof(sen_sof), .sen_eof(sen_eof), .mem_sof(mem_sof), .mem_eof(mem_eof),
      .frame_start(frame_start), .start_is_mem(start_is_mem), .busy(busy)
   );

   frc_shadow_bank #(.NUM_SHD(NUM_SHD), .SHD_W(SHD_W)) u_shd (
      .clk(clk), .rst_n(rst_n), .wr(shd_wr), .addr(shd_addr), .wdata(shd_wdata),
      .commit(frame_start), .rdata(shd_rdata), .active(shd_active)
   );

   assign proc_en = busy;
endmodule

// File: rtl/frc_checker.sv
module frc_checker #(
   parameter int CTL_W   = 8,
   parameter int NUM_SHD = 4,
   parameter int SHD_W   = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     ctl_wr,
   input logic [CTL_W-1:0]         ctl_wdata,
   input logic [CTL_W-1:0]         ctl_rdata,
   input logic [NUM_SHD*SHD_W-1:0] shd_active,
   input logic                     sen_sof,
   input logic                     sen_eof,
   input logic                     mem_sof,
   input logic                     mem_eof,
   input logic                     fetch_start,
   input logic                     busy
);
   a_r2_mem_arm_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctl_wr && ctl_wdata[0] && ctl_wdata[4]) |-> (fetch_start && ctl_rdata == '0));

   a_r2_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_start |-> $past(ctl_wr && ctl_wdata[0] && ctl_wdata[4]));

   a_r7_rise_on_sof: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(mem_sof || sen_sof));

   a_r6_fall_on_eof: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(mem_eof || sen_eof));

   a_r8_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(busy) |-> $stable(shd_active));
endmodule

bind frame_run_ctrl frc_checker #(.CTL_W(CTL_W), .NUM_SHD(NUM_SHD), .SHD_W(SHD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
   .shd_active(shd_active), .sen_sof(sen_sof), .sen_eof(sen_eof), .mem_sof(mem_sof),
   .mem_eof(mem_eof), .fetch_start(fetch_start), .busy(busy)
);

// File: tb/frame_run_ctrl_bench.sv
`timescale 1ns/1ps
module frame_run_ctrl_bench;
   localparam int CTL_W = 8;
   localparam int N     = 4;
   localparam int W     = 16;
   localparam int AW    = $clog2(N);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_wr = 1'b0;
   logic [CTL_W-1:0] ctl_wdata = '0;
   logic [CTL_W-1:0] ctl_rdata;
   logic shd_wr = 1'b0;
   logic [AW-1:0] shd_addr = '0;
   logic [W-1:0] shd_wdata = '0;
   logic [W-1:0] shd_rdata;
   logic [N*W-1:0] shd_active;
   logic sen_sof = 1'b0, sen_eof = 1'b0, mem_sof = 1'b0, mem_eof = 1'b0;
   logic fetch_start, proc_en, busy;

   always #2.5 clk = ~clk;

   frame_run_ctrl #(.CTL_W(CTL_W), .NUM_SHD(N), .SHD_W(W)) u_frame_run_ctrl (.*);

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference state, built from the requirements
   bit m_en, m_one, m_src, m_pend, m_busy, m_cur_mem, m_fetch;
   logic [W-1:0] m_stg [N];
   logic [W-1:0] m_act [N];

   function automatic logic [CTL_W-1:0] exp_ctl();
      logic [CTL_W-1:0] v = '0;
      v[0] = m_en; v[3] = m_one; v[4] = m_src;
      return v;
   endfunction

   task automatic model_reset();
      m_en = 0; m_one = 0; m_src = 0; m_pend = 0; m_busy = 0; m_cur_mem = 0; m_fetch = 0;
      for (int i = 0; i < N; i++) begin m_stg[i] = '0; m_act[i] = '0; end
   endtask

   task automatic model_step();
      bit start, smem;
      smem  = m_pend && mem_sof;
      start = !m_busy && (smem || (m_en && !m_src && sen_sof));
      if (start) begin
         m_busy = 1; m_cur_mem = smem;
         for (int i = 0; i < N; i++) m_act[i] = m_stg[i];
      end else if (m_busy && (m_cur_mem ? mem_eof : sen_eof)) m_busy = 0;
      m_fetch = 0;
      if (start && smem) m_pend = 0;
      if (start && !smem && m_one) begin m_en = 0; m_one = 0; m_src = 0; end
      if (ctl_wr) begin
         if (ctl_wdata[0] && ctl_wdata[4]) begin
            m_en = 0; m_one = 0; m_src = 0; m_pend = 1; m_fetch = 1;
         end else begin
            m_en = ctl_wdata[0]; m_one = ctl_wdata[3]; m_src = ctl_wdata[4];
         end
      end
      if (shd_wr) m_stg[shd_addr] = shd_wdata;
   endtask

   task automatic chk(input bit ok, input string what, input string req,
                      input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic compare();
      chk(busy === m_busy, "busy", "R3 R4 R6 R7", 64'(busy), 64'(m_busy));
      chk(proc_en === m_busy, "proc_en", "R7", 64'(proc_en), 64'(m_busy));
      chk(fetch_start === m_fetch, "fetch_start", "R2", 64'(fetch_start), 64'(m_fetch));
      chk(ctl_rdata === exp_ctl(), "ctl_rdata", "R2 R5", 64'(ctl_rdata), 64'(exp_ctl()));
      chk(shd_rdata === m_stg[shd_addr], "shd_rdata", "R8", 64'(shd_rdata), 64'(m_stg[shd_addr]));
      for (int i = 0; i < N; i++)
         chk(shd_active[i*W +: W] === m_act[i], "shd_active", "R8 R9",
             64'(shd_active[i*W +: W]), 64'(m_act[i]));
   endtask

   task automatic tick();
      model_step();
      @(negedge clk);
      ctl_wr = 0; shd_wr = 0; sen_sof = 0; sen_eof = 0; mem_sof = 0; mem_eof = 0;
      compare();
   endtask

   task automatic wr_ctl(input logic [CTL_W-1:0] v);
      ctl_wr = 1; ctl_wdata = v; tick();
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      // R1: reset state
      compare();
      chk(ctl_rdata === '0 && !busy && !fetch_start, "reset", "R1", 64'(ctl_rdata), 64'h0);
      rst_n = 1;
      @(negedge clk); compare();

      // R2 R3: memory arm with single-frame bit clear, one frame only
      wr_ctl(8'h11);
      tick();
      mem_sof = 1; tick();
      chk(busy === 1'b1, "mem frame start", "R3", 64'(busy), 64'h1);
      mem_sof = 1; tick();                 // R7: start ignored while busy
      sen_eof = 1; tick();                 // R7: wrong-source end ignored
      chk(busy === 1'b1, "wrong eof", "R7", 64'(busy), 64'h1);
      mem_eof = 1; tick();
      mem_sof = 1; tick();                 // R3: not re-armed
      chk(busy === 1'b0, "mem no rearm", "R3", 64'(busy), 64'h0);

      // R4 R6: continuous sensor, deferred disable
      wr_ctl(8'h01);
      repeat (3) tick();
      chk(busy === 1'b0, "wait for sof", "R4", 64'(busy), 64'h0);
      sen_sof = 1; tick();
      wr_ctl(8'h00);
      repeat (2) tick();
      chk(busy === 1'b1, "deferred disable", "R6", 64'(busy), 64'h1);
      sen_eof = 1; tick();
      sen_sof = 1; tick();
      chk(busy === 1'b0, "no restart", "R6", 64'(busy), 64'h0);

      // R5: sensor single-frame
      wr_ctl(8'h09);
      sen_sof = 1; tick();
      chk(ctl_rdata === '0, "self clear", "R5", 64'(ctl_rdata), 64'h0);
      sen_eof = 1; tick();

      // R8 R9: shadow write meeting a frame start
      shd_wr = 1; shd_addr = 2; shd_wdata = 16'hA5A5; tick();
      wr_ctl(8'h01);
      shd_wr = 1; shd_addr = 2; shd_wdata = 16'h5A5A; sen_sof = 1; tick();
      chk(shd_active[2*W +: W] === 16'hA5A5, "same-cycle commit", "R9",
          64'(shd_active[2*W +: W]), 64'hA5A5);
      chk(shd_rdata === 16'h5A5A, "staged readback", "R8", 64'(shd_rdata), 64'h5A5A);
      wr_ctl(8'h00);
      sen_eof = 1; tick();

      // constrained random mix
      void'($urandom(32'h1F2E3D4C));
      for (int c = 0; c < 4000; c++) begin
         ctl_wr    = ($urandom % 10) == 0;
         ctl_wdata = CTL_W'($urandom) & 8'h19;
         shd_wr    = ($urandom % 4) == 0;
         shd_addr  = AW'($urandom);
         shd_wdata = W'($urandom);
         sen_sof   = ($urandom % 8) == 0;
         sen_eof   = ($urandom % 8) == 0;
         mem_sof   = ($urandom % 8) == 0;
         mem_eof   = ($urandom % 8) == 0;
         tick();
      end
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog R1 actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule